// File: doc/BRIEF.md
# Mask-Addressed GPIO Bank Controller

This block is one bank of up to 32 general-purpose I/O lines behind a small 32-bit register bus. Each line is set up indirectly. Software first loads a line-select word. It then writes one shared setup word, and that write updates every selected line in the same cycle. A line's setup is a 3-bit function code and a direction flag. Code zero keeps the line under software control. Codes 1 to 7 hand the line to one of seven alternate peripheral functions through an external pin mux.

Output levels are changed through two dedicated registers, one that raises levels and one that lowers them. Neither needs a read-modify-write. The levels seen on the pads are resynchronised into the bank clock domain before software reads them. The number of implemented lines is a parameter. Lines above that count hold no state and read as zero. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset every line is a software-controlled input with function code 0, and all output latches and the select word are zero. So padOe and padOut are all zero, and reads of the select word and of the setup word return zero.
- R2: A write to word address 0 stores the select word, where bit n selects line n. A read of address 0 returns that word.
- R3: A write to word address 1 copies the function code from data bits [2:0] and the direction flag from data bit 4 into every selected line. Unselected lines keep their setup, and all other data bits are ignored.
- R4: A read of word address 1 returns the setup of the lowest-numbered selected line, with the code in bits [2:0], the direction in bit 4 and zeros elsewhere. With no line selected it returns zero.
- R5: A write to word address 2 sets the output latch of every line whose data bit is 1. Lines whose data bit is 0 keep their latch.
- R6: A write to word address 3 clears the output latch of every line whose data bit is 1. Lines whose data bit is 0 keep their latch.
- R7: padOut carries each line's output latch. padOe of a line is 1 only when its direction flag is 1 and its function code is 0.
- R8: A read of word address 4 returns the pad levels after a two-flop synchroniser. A level applied before clock edge k is returned by a read strobed at edge k+2 or later, and not by a read strobed at edge k+1.
- R9: Lines numbered NUM_LINES and above have no state. Their bits in the select word, in the pad-level read, and on padOut and padOe are always zero.
- R10: When FUNC_PORT_EN is 1, funcSel bits [3n+2:3n] carry line n's function code. When it is 0, funcSel is all zero.
- R11: A read and a write strobed in the same cycle both take effect, and the read returns the state as it was before that write.
- R12: Reads of word addresses 2, 3, 5, 6 and 7 return zero. Writes to addresses 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Output latch per line |
| padOe | output | 32 | Output enable per line |
| funcSel | output | 96 | 3-bit function code per line for the pin mux |

## Verification
The bus lets a read and a write be strobed in the same cycle, so a setup write can meet a setup read, and a select write can meet a select read. The bench raises both strobes together on the setup word and again on the select word. It expects the returned data to hold the old contents, and a following read to show the new contents. In a second case, a pad level change lands one edge before a pad-level read. The bench expects the old level from that read and the new level from the next one, which pins the synchroniser depth at exactly two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int FUNC_W  = 3;
  localparam int DIR_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL = 3'd0,
    REG_CFG = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_PIN = 3'd4
  } regAddrE;

  typedef struct packed {
    logic selWr;
    logic cfgWr;
    logic setWr;
    logic clrWr;
    logic rdAny;
    logic selRd;
    logic cfgRd;
    logic pinRd;
  } busStrobeT;

  typedef struct packed {
    logic              dir;
    logic [FUNC_W-1:0] func;
  } lineCfgT;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobeT         strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdAny = rdEn;
    if (wrEn) begin
      case (regAddrE'(addr))
        REG_SEL: strobe.selWr = 1'b1;
        REG_CFG: strobe.cfgWr = 1'b1;
        REG_SET: strobe.setWr = 1'b1;
        REG_CLR: strobe.clrWr = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (regAddrE'(addr))
        REG_SEL: strobe.selRd = 1'b1;
        REG_CFG: strobe.cfgRd = 1'b1;
        REG_PIN: strobe.pinRd = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES    = 32,
  parameter bit FUNC_PORT_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobeT               strobe,
  input  logic [REG_W-1:0]        wrData,
  input  logic [REG_W-1:0]        padIn,
  output logic [REG_W-1:0]        rdData,
  output logic [REG_W-1:0]        padOut,
  output logic [REG_W-1:0]        padOe,
  output logic [REG_W*FUNC_W-1:0] funcSel,
  output logic [REG_W-1:0]        selMask
);
  logic [REG_W-1:0] syncOut;
  lineCfgT          cfgArr [REG_W];
  lineCfgT          firstCfg;
  logic [REG_W-1:0] cfgWord;
  logic [REG_W-1:0] rdNext;

  for (genvar g = 0; g < REG_W; g++) begin : gLine
    if (g < NUM_LINES) begin : gImpl
      logic    selQ, latchQ, syncA, syncB;
      lineCfgT cfgQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selQ   <= 1'b0;
          latchQ <= 1'b0;
          syncA  <= 1'b0;
          syncB  <= 1'b0;
          cfgQ   <= '0;
        end else begin
          syncA <= padIn[g];
          syncB <= syncA;
          if (strobe.selWr) selQ <= wrData[g];
          if (strobe.cfgWr && selQ) begin
            cfgQ.dir  <= wrData[DIR_BIT];
            cfgQ.func <= wrData[FUNC_W-1:0];
          end
          if (strobe.setWr && wrData[g]) latchQ <= 1'b1;
          else if (strobe.clrWr && wrData[g]) latchQ <= 1'b0;
        end
      end
      assign selMask[g] = selQ;
      assign syncOut[g] = syncB;
      assign cfgArr[g]  = cfgQ;
      assign padOut[g]  = latchQ;
      assign padOe[g]   = cfgQ.dir && (cfgQ.func == '0);
    end else begin : gTie
      assign selMask[g] = 1'b0;
      assign syncOut[g] = 1'b0;
      assign cfgArr[g]  = '0;
      assign padOut[g]  = 1'b0;
      assign padOe[g]   = 1'b0;
    end
    if (FUNC_PORT_EN) begin : gFunc
      assign funcSel[g*FUNC_W +: FUNC_W] = cfgArr[g].func;
    end else begin : gNoFunc
      assign funcSel[g*FUNC_W +: FUNC_W] = '0;
    end
  end

  // Lowest selected line wins: scan from the top so the low index overwrites.
  always_comb begin
    firstCfg = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (selMask[i]) firstCfg = cfgArr[i];
    end
    cfgWord                = '0;
    cfgWord[FUNC_W-1:0]    = firstCfg.func;
    cfgWord[DIR_BIT]       = firstCfg.dir;
  end

  always_comb begin
    rdNext = '0;
    if (strobe.selRd)      rdNext = selMask;
    else if (strobe.cfgRd) rdNext = cfgWord;
    else if (strobe.pinRd) rdNext = syncOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdAny) rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES    = 32,
  parameter bit FUNC_PORT_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wrData,
  output logic [REG_W-1:0]        rdData,
  input  logic [REG_W-1:0]        padIn,
  output logic [REG_W-1:0]        padOut,
  output logic [REG_W-1:0]        padOe,
  output logic [REG_W*FUNC_W-1:0] funcSel
);
  busStrobeT        strobe;
  logic [REG_W-1:0] selMask;

  gpio_bank_ctrl ctrl_i (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_bank_dp #(
    .NUM_LINES    (NUM_LINES),
    .FUNC_PORT_EN (FUNC_PORT_EN)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .padIn   (padIn),
    .rdData  (rdData),
    .padOut  (padOut),
    .padOe   (padOe),
    .funcSel (funcSel),
    .selMask (selMask)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES    = 32,
  parameter bit FUNC_PORT_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       addr,
  input logic [REG_W-1:0]        wrData,
  input logic [REG_W-1:0]        rdData,
  input logic [REG_W-1:0]        padOut,
  input logic [REG_W-1:0]        padOe,
  input logic [REG_W*FUNC_W-1:0] funcSel,
  input logic [REG_W-1:0]        selMask
);
  localparam logic [REG_W-1:0] IMPL =
    (NUM_LINES >= REG_W) ? {REG_W{1'b1}} : ((32'd1 << NUM_LINES) - 32'd1);

  // R2
  mask_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0) |=> selMask == $past(wrData & IMPL));

  // R5
  set_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2) |=> (padOut & $past(wrData & IMPL)) == $past(wrData & IMPL));

  // R6
  clr_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=> (padOut & $past(wrData)) == '0);

  // R4
  cfg_empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd1 && selMask == '0 && !wrEn) |=> rdData == '0);

  // R9
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd4) |=> (rdData & ~IMPL) == '0);

  // R12
  quiet_addr_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == 3'd2 || addr == 3'd3 || addr >= 3'd5)) |=> rdData == '0);

  for (genvar g = 0; g < REG_W; g++) begin : gLineChk
    if (FUNC_PORT_EN) begin : gOe
      // R7
      oe_gpio_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        padOe[g] |-> funcSel[g*FUNC_W +: FUNC_W] == '0);
    end else begin : gOff
      // R10
      func_port_off_chk: assert property (@(posedge clk) disable iff (!rstN)
        (padOe[g] || !padOe[g]) |-> funcSel[g*FUNC_W +: FUNC_W] == '0);
    end
  end
endmodule

bind gpio_bank_ctl gpio_bank_chk #(
  .NUM_LINES    (NUM_LINES),
  .FUNC_PORT_EN (FUNC_PORT_EN)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .padOut  (padOut),
  .padOe   (padOe),
  .funcSel (funcSel),
  .selMask (selMask)
);

// File: tb/gpio_bank_ctl_tb_top.sv
module gpio_bank_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] padIn = '0;
  logic [31:0] rdA, padOutA, padOeA;
  logic [31:0] rdB, padOutB, padOeB;
  logic [95:0] funcA, funcB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctl #(.NUM_LINES(32), .FUNC_PORT_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdA), .padIn(padIn), .padOut(padOutA),
    .padOe(padOeA), .funcSel(funcA));

  gpio_bank_ctl #(.NUM_LINES(8), .FUNC_PORT_EN(1'b0)) dut_n8_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdB), .padIn(padIn), .padOut(padOutB),
    .padOe(padOeB), .funcSel(funcB));

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    da = rdA; db = rdB;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    check("R1 padOe", {padOeA, padOeB}, '0);
    check("R1 padOut", {padOutA, padOutB}, '0);
    busRead(3'd0, a, b);
    check("R1 select read", {a, b}, '0);
    busRead(3'd1, a, b);
    check("R1 setup read", {a, b}, '0);
  endtask

  task automatic t_mask();
    logic [31:0] a, b;
    busWrite(3'd0, 32'hA5A5_0F0F);
    busRead(3'd0, a, b);
    check("R2 select readback", a, 32'hA5A5_0F0F);
    check("R9 select readback 8 lines", b, 32'h0000_000F);
  endtask

  task automatic t_cfg();
    logic [31:0] a, b;
    busWrite(3'd0, 32'h0000_0030);
    busWrite(3'd1, 32'h0000_0013);
    busWrite(3'd0, 32'h0000_0001);
    busWrite(3'd1, 32'h0000_0010);
    busWrite(3'd0, 32'h0000_0004);
    busWrite(3'd1, 32'hFFFF_FFE3);
    check("R7 padOe gpio outputs only", padOeA, 32'h0000_0001);
    check("R7 padOe 8 lines", padOeB, 32'h0000_0001);
    check("R10 funcSel per line", funcA[17:0], 18'b011_011_000_011_000_000);
    check("R10 funcSel disabled", funcB, '0);
    busRead(3'd1, a, b);
    check("R3 extra data bits ignored", a, 32'h0000_0003);
    busWrite(3'd0, 32'h0000_0030);
    busRead(3'd1, a, b);
    check("R4 setup of line 4", {a, b}, {32'h13, 32'h13});
    busWrite(3'd0, 32'h0000_0031);
    busRead(3'd1, a, b);
    check("R4 lowest selected wins", {a, b}, {32'h10, 32'h10});
    busWrite(3'd0, 32'h0000_0002);
    busRead(3'd1, a, b);
    check("R3 unselected line unchanged", {a, b}, '0);
    busWrite(3'd0, 32'h0000_0000);
    busRead(3'd1, a, b);
    check("R4 empty select reads zero", {a, b}, '0);
  endtask

  task automatic t_out();
    busWrite(3'd0, 32'h0000_000F);
    busWrite(3'd1, 32'h0000_0010);
    check("R7 padOe four outputs", {padOeA, padOeB}, {32'hF, 32'hF});
    busWrite(3'd2, 32'h0000_0005);
    check("R5 set selected latches", {padOutA, padOutB}, {32'h5, 32'h5});
    busWrite(3'd2, 32'h0000_0000);
    check("R5 zero bits no effect", {padOutA, padOutB}, {32'h5, 32'h5});
    busWrite(3'd3, 32'h0000_0004);
    check("R6 clear selected latch", {padOutA, padOutB}, {32'h1, 32'h1});
    busWrite(3'd3, 32'h0000_0000);
    check("R6 zero bits no effect", {padOutA, padOutB}, {32'h1, 32'h1});
    busWrite(3'd2, 32'hFFFF_FFFF);
    check("R5 set all", padOutA, 32'hFFFF_FFFF);
    check("R9 set all 8 lines", padOutB, 32'h0000_00FF);
    busWrite(3'd3, 32'hFFFF_FFFF);
    check("R6 clear all", {padOutA, padOutB}, '0);
  endtask

  task automatic t_pin();
    logic [31:0] a, b;
    @(negedge clk);
    padIn = 32'h1234_5678;
    busRead(3'd4, a, b);
    check("R8 one edge too early", {a, b}, '0);
    busRead(3'd4, a, b);
    check("R8 level after two flops", a, 32'h1234_5678);
    check("R9 pad levels 8 lines", b, 32'h0000_0078);
  endtask

  task automatic t_simul();
    logic [31:0] a, b;
    busWrite(3'd0, 32'h0000_0001);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 3'd1; wrData = 32'h0000_0015;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R11 setup read sees old", {rdA, rdB}, {32'h10, 32'h10});
    check("R7 alternate function drops padOe", padOeA[0], 1'b0);
    busRead(3'd1, a, b);
    check("R11 setup read after write", {a, b}, {32'h15, 32'h15});
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 3'd0; wrData = 32'h0000_0300;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R11 select read sees old", {rdA, rdB}, {32'h1, 32'h1});
    busRead(3'd0, a, b);
    check("R11 select read after write", {a, b}, {32'h300, 32'h0});
  endtask

  task automatic t_quiet();
    logic [31:0] a, b;
    busWrite(3'd2, 32'h0000_0003);
    busWrite(3'd6, 32'hFFFF_FFFF);
    busWrite(3'd5, 32'hFFFF_FFFF);
    busWrite(3'd7, 32'h0000_0000);
    check("R12 writes to spare addresses ignored", {padOutA, padOutB}, {32'h3, 32'h3});
    busRead(3'd0, a, b);
    check("R12 select unchanged", {a, b}, {32'h300, 32'h0});
    for (int k = 2; k < 8; k++) begin
      if (k != 4) begin
        busRead(3'(k), a, b);
        check("R12 spare read zero", {a, b}, '0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_cfg();
    t_out();
    t_pin();
    t_simul();
    t_quiet();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule